// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit carries out four single-byte operations for an 8-bit accumulator CPU: test one bit, clear one bit, set one bit, and rotate left through the carry flag. A decoder upstream hands it an operation code, a bit index and an operand selector with a one-cycle start strobe. The unit then fetches the operand from either a register-file read port or, for the memory-indirect selector, from the byte at the address held in the HL pair. It computes the result, writes it back and updates the flag byte where the operation calls for it. It also reports how many cycles the operation costs.

Memory is reached through a byte port that carries one request at a time. A request is held until `mem_ready_i` is seen high at a clock edge. Read-modify-write operands are read first and then written to the same address. The unit accepts a new operation only while idle. It raises `done_o` for a single cycle when the operation finishes, and that cycle is also the cycle in which register and flag writes are presented.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 (test) writes flags with Z (bit 7) equal to the inverse of operand bit `bit_idx_i`, N (bit 6) = 0, H (bit 5) = 1 and C (bit 4) kept from `flag_i`. It writes neither the register nor memory.
- R2: Operation code 1 (clear) writes back the operand AND NOT (1 << `bit_idx_i`) and leaves the flags unwritten.
- R3: Operation code 2 (set) writes back the operand OR (1 << `bit_idx_i`) and leaves the flags unwritten.
- R4: When memory answers at once, `done_o` is high in the N-th cycle after the edge that samples `start_i`, and `cycles_o` equals N during that cycle. N is:
  - 8 for a register operand;
  - 12 for a memory test;
  - 16 for a memory clear, set or rotate;
  - 4 for the accumulator rotate;
  - 1 for an illegal selector.
- R5: Operation code 3 (rotate) with `acc_form_i` = 0 writes {operand[6:0], old C}. It sets C to operand bit 7, Z to (result == 0), and clears N and H.
- R6: Operation code 3 with `acc_form_i` = 1 works on A (register address 7) whatever `sel_i` holds. It forces Z to 0, clears N and H, and sets C from the bit shifted out.
- R7: The selector codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 the memory byte at `hl_i`, and 7 A. The register-file address equals the code. Any code of 8 or above is illegal: it finishes with `err_o` high alongside `done_o` and writes nothing.
- R8: A memory operand is read at `hl_i`. Clear, set and rotate then write to the same address, and the write is issued only after the read has been accepted. A test never writes. A memory stall delays completion but never shortens it.
- R9: `done_o` lasts exactly one cycle. `rf_we_o` and `flag_we_o` are high only in that cycle.
- R10: Every flag byte written has its low nibble at zero.
- R11: `start_i` is ignored while `busy_o` is high. The running operation is unaffected, and nothing extra runs afterwards.
- R12: After reset, `busy_o`, `done_o`, `mem_req_o`, `rf_we_o` and `flag_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured when idle |
| op_i | input | 2 | 0 test, 1 clear, 2 set, 3 rotate |
| acc_form_i | input | 1 | Accumulator-only rotate form |
| bit_idx_i | input | IDX_W (3) | Bit index |
| sel_i | input | SEL_W (4) | Operand selector |
| hl_i | input | ADDR_W (16) | HL pair value, the memory operand address |
| flag_i | input | 8 | Current flag byte |
| rf_raddr_o | output | 3 | Register read address |
| rf_rdata_i | input | DATA_W (8) | Register read data, combinational |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 3 | Register write address |
| rf_wdata_o | output | DATA_W (8) | Register write data |
| flag_we_o | output | 1 | Flag write enable |
| flag_o | output | 8 | New flag byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W (16) | Memory address |
| mem_wdata_o | output | DATA_W (8) | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request this edge |
| mem_rdata_i | input | DATA_W (8) | Memory read data, valid with ready |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal selector, valid with done |
| cycles_o | output | CNT_W (5) | Cost of the current operation |

## Verification
The bench builds the unit with its default parameters: an 8-bit datapath, a 4-bit selector, a 16-bit address and the default cycle costs. The 4-bit selector makes codes 8 to 15 reachable, so the illegal-selector path can be driven at the ports. The default costs make the fixed completion cycles of 4, 8, 12 and 16 directly comparable with a cycle counter in the bench. A held-off memory ready shows that a short stall is absorbed inside the 16-cycle window.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    OP_TEST = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_ROTL = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    PH_GET = 2'd0,
    PH_RD  = 2'd1,
    PH_WR  = 2'd2,
    PH_FIN = 2'd3
  } phase_e;

  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam logic [2:0] SEL_ACC = 3'd7;

  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  bop_e              op_i,
  input  logic              acc_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [7:0]        flag_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        flag_o
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rot;

  always_comb begin
    mask   = DATA_W'(1) << idx_i;
    rot    = {opnd_i[DATA_W-2:0], flag_i[FC]};
    res_o  = opnd_i;
    flag_o = {flag_i[7:4], 4'b0000};
    unique case (op_i)
      OP_TEST: begin
        flag_o[FZ] = ~opnd_i[idx_i];
        flag_o[FN] = 1'b0;
        flag_o[FH] = 1'b1;
      end
      OP_CLR:  res_o = opnd_i & ~mask;
      OP_SET:  res_o = opnd_i | mask;
      OP_ROTL: begin
        res_o      = rot;
        flag_o[FZ] = acc_i ? 1'b0 : (rot == '0);
        flag_o[FN] = 1'b0;
        flag_o[FH] = 1'b0;
        flag_o[FC] = opnd_i[DATA_W-1];
      end
      default: res_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int IDX_W      = $clog2(DATA_W),
  parameter int SEL_W      = 4,
  parameter int ADDR_W     = 16,
  parameter int COST_REG   = 8,
  parameter int COST_MRD   = 12,
  parameter int COST_RMW   = 16,
  parameter int COST_ACC   = 4,
  parameter int COST_ERR   = 1,
  parameter int CNT_W      = $clog2(COST_RMW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              acc_form_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [7:0]        flag_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output bop_e              op_o,
  output logic              acc_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] opnd_o,
  output logic [7:0]        flag_o,
  output logic [2:0]        rf_addr_o,
  output logic              rf_we_o,
  output logic              flag_we_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  cycles_o
);

  logic              busy_q, busy_d;
  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cost_q, cost_d;
  bop_e              op_q, op_d;
  logic              acc_q, acc_d, ill_q, ill_d, mem_q, mem_d;
  logic [2:0]        sel_q, sel_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] hl_q, hl_d;
  logic [7:0]        flg_q, flg_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;
  logic              accept, load_ctx, done;
  logic              n_acc, n_ill, n_mem;

  assign accept = start_i & ~busy_q;
  assign done   = busy_q & (ph_q == PH_FIN) & (cnt_q >= cost_q);
  assign n_acc  = acc_form_i & (op_i == OP_ROTL);
  assign n_ill  = ~n_acc & ((sel_i >> 3) != '0);
  assign n_mem  = ~n_acc & ~n_ill & (sel_i[2:0] == SEL_MEM);

  // next state
  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cost_d = cost_q;
    op_d   = op_q;
    acc_d  = acc_q;
    ill_d  = ill_q;
    mem_d  = mem_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    hl_d   = hl_q;
    flg_d  = flg_q;
    opnd_d = opnd_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
      op_d   = bop_e'(op_i);
      acc_d  = n_acc;
      ill_d  = n_ill;
      mem_d  = n_mem;
      sel_d  = n_acc ? SEL_ACC : sel_i[2:0];
      idx_d  = bit_idx_i;
      hl_d   = hl_i;
      flg_d  = flag_i;
      if (n_ill)                 cost_d = CNT_W'(COST_ERR);
      else if (n_acc)            cost_d = CNT_W'(COST_ACC);
      else if (!n_mem)           cost_d = CNT_W'(COST_REG);
      else if (op_i == OP_TEST)  cost_d = CNT_W'(COST_MRD);
      else                       cost_d = CNT_W'(COST_RMW);
      ph_d = n_ill ? PH_FIN : (n_mem ? PH_RD : PH_GET);
    end else if (busy_q) begin
      if (cnt_q < cost_q) cnt_d = cnt_q + CNT_W'(1);
      unique case (ph_q)
        PH_GET: begin
          opnd_d = rf_rdata_i;
          ph_d   = PH_FIN;
        end
        PH_RD: if (mem_ready_i) begin
          opnd_d = mem_rdata_i;
          ph_d   = (op_q == OP_TEST) ? PH_FIN : PH_WR;
        end
        PH_WR: if (mem_ready_i) ph_d = PH_FIN;
        PH_FIN: if (done) busy_d = 1'b0;
        default: ph_d = PH_FIN;
      endcase
    end
  end

  assign load_ctx = accept;

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_FIN;
      cnt_q  <= '0;
      cost_q <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      cost_q <= cost_d;
    end
  end

  // context registers, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_TEST;
      acc_q <= 1'b0;
      ill_q <= 1'b0;
      mem_q <= 1'b0;
      sel_q <= '0;
      idx_q <= '0;
      hl_q  <= '0;
      flg_q <= '0;
    end else if (load_ctx) begin
      op_q  <= op_d;
      acc_q <= acc_d;
      ill_q <= ill_d;
      mem_q <= mem_d;
      sel_q <= sel_d;
      idx_q <= idx_d;
      hl_q  <= hl_d;
      flg_q <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                opnd_q <= '0;
    else if (opnd_d != opnd_q) opnd_q <= opnd_d;
  end

  assign op_o       = op_q;
  assign acc_o      = acc_q;
  assign idx_o      = idx_q;
  assign opnd_o     = opnd_q;
  assign flag_o     = flg_q;
  assign rf_addr_o  = sel_q;
  assign busy_o     = busy_q;
  assign done_o     = done;
  assign err_o      = done & ill_q;
  assign cycles_o   = cost_q;
  assign rf_we_o    = done & ~ill_q & ~mem_q & (op_q != OP_TEST);
  assign flag_we_o  = done & ~ill_q & ((op_q == OP_TEST) | (op_q == OP_ROTL));
  assign mem_req_o  = busy_q & ((ph_q == PH_RD) | (ph_q == PH_WR));
  assign mem_we_o   = busy_q & (ph_q == PH_WR);
  assign mem_addr_o = hl_q;

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = $clog2(DATA_W),
  parameter int SEL_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int COST_REG = 8,
  parameter int COST_MRD = 12,
  parameter int COST_RMW = 16,
  parameter int COST_ACC = 4,
  parameter int COST_ERR = 1,
  parameter int CNT_W    = $clog2(COST_RMW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              acc_form_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [7:0]        flag_i,
  output logic [2:0]        rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [2:0]        rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              flag_we_o,
  output logic [7:0]        flag_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  cycles_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bop_e              op_w;
  logic              acc_w;
  logic [IDX_W-1:0]  idx_w;
  logic [DATA_W-1:0] opnd_w, res_w;
  logic [7:0]        flg_in_w;
  logic [2:0]        addr_w;

  bitop_ctrl #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .COST_REG(COST_REG), .COST_MRD(COST_MRD), .COST_RMW(COST_RMW),
    .COST_ACC(COST_ACC), .COST_ERR(COST_ERR), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .acc_form_i (acc_form_i),
    .bit_idx_i  (bit_idx_i),
    .sel_i      (sel_i),
    .hl_i       (hl_i),
    .flag_i     (flag_i),
    .rf_rdata_i (rf_rdata_i),
    .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i),
    .op_o       (op_w),
    .acc_o      (acc_w),
    .idx_o      (idx_w),
    .opnd_o     (opnd_w),
    .flag_o     (flg_in_w),
    .rf_addr_o  (addr_w),
    .rf_we_o    (rf_we_o),
    .flag_we_o  (flag_we_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .cycles_o   (cycles_o)
  );

  bitop_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) alu_i (
    .op_i  (op_w),
    .acc_i (acc_w),
    .idx_i (idx_w),
    .opnd_i(opnd_w),
    .flag_i(flg_in_w),
    .res_o (res_w),
    .flag_o(flag_o)
  );

  assign rf_raddr_o  = addr_w;
  assign rf_waddr_o  = addr_w;
  assign rf_wdata_o  = res_w;
  assign mem_wdata_o = res_w;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              rf_we_o,
  input logic              flag_we_o,
  input logic [7:0]        flag_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [CNT_W-1:0]  cycles_o
);

  logic [1:0]        op_l;
  logic [15:0]       cnt_l;
  logic              rd_ok;
  logic [ADDR_W-1:0] rd_addr;
  logic              acc;

  assign acc = start_i & ~busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_l    <= 2'd0;
      cnt_l   <= '0;
      rd_ok   <= 1'b0;
      rd_addr <= '0;
    end else begin
      if (acc) begin
        op_l  <= op_i;
        cnt_l <= 16'd1;
        rd_ok <= 1'b0;
      end else if (busy_o && cnt_l != 16'hFFFF) begin
        cnt_l <= cnt_l + 16'd1;
      end
      if (mem_req_o && !mem_we_o && mem_ready_i) begin
        rd_ok   <= 1'b1;
        rd_addr <= mem_addr_o;
      end
    end
  end

  a_r1_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o || (mem_req_o && mem_we_o)) |-> (op_l != 2'd0));
  a_r2_no_flag_on_bitwrite: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> (op_l == 2'd0 || op_l == 2'd3));
  a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ({{(16-CNT_W){1'b0}}, cycles_o} <= cnt_l));
  a_r7_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && !rf_we_o && !flag_we_o && !mem_req_o));
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (rd_ok && mem_addr_o == rd_addr));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_commit_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o || flag_we_o) |-> done_o);
  a_r10_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> (flag_o[3:0] == 4'h0));
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> (busy_o && $stable(cycles_o)));

endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .op_i(op_i),
  .rf_we_o(rf_we_o), .flag_we_o(flag_we_o), .flag_o(flag_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ready_i(mem_ready_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .cycles_o(cycles_o)
);

// File: tb/bitop_unit_tb_top.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        accf = 1'b0;
  logic [2:0]  idx = 3'd0;
  logic [3:0]  sel = 4'd0;
  logic [15:0] hl = 16'h0;
  logic [7:0]  flag_r = 8'h0;
  logic [7:0]  rf [8];
  logic [2:0]  rf_raddr, rf_waddr;
  logic        rf_we, flag_we, mem_req, mem_we, busy, done, err;
  logic [7:0]  rf_wdata, flag_nx, mem_wdata;
  logic [15:0] mem_addr;
  logic        mem_rdy = 1'b1;
  logic [7:0]  mem_byte = 8'h0;
  logic [4:0]  cycles;
  int          rd_cnt, wr_cnt, order_bad;
  logic [15:0] wr_addr;
  int          checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .acc_form_i(accf),
    .bit_idx_i(idx), .sel_i(sel), .hl_i(hl), .flag_i(flag_r),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf[rf_raddr]), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .flag_we_o(flag_we),
    .flag_o(flag_nx), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_rdy),
    .mem_rdata_i(mem_byte), .busy_o(busy), .done_o(done), .err_o(err),
    .cycles_o(cycles)
  );

  // register file, flag byte and memory models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (flag_we) flag_r <= flag_nx;
    if (mem_req && mem_rdy && !mem_we) rd_cnt <= rd_cnt + 1;
    if (mem_req && mem_rdy && mem_we) begin
      wr_cnt   <= wr_cnt + 1;
      wr_addr  <= mem_addr;
      mem_byte <= mem_wdata;
      if (rd_cnt == 0) order_bad <= 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic       acc;
    logic [2:0] idx;
    logic [3:0] sel;
    logic [7:0] opnd;
    logic [7:0] fin;
    logic [7:0] eres;
    logic [7:0] eflg;
    logic [4:0] ecost;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 3'd3, 4'd0, 8'h08, 8'h50, 8'h08, 8'h30, 5'd8 },  // R1 B bit set
    '{2'd0, 1'b0, 3'd0, 4'd7, 8'hFE, 8'hC0, 8'hFE, 8'hA0, 5'd8 },  // R1 A bit clear
    '{2'd0, 1'b0, 3'd7, 4'd6, 8'h80, 8'h10, 8'h80, 8'h30, 5'd12},  // R1 R8 memory test
    '{2'd1, 1'b0, 3'd3, 4'd1, 8'hFF, 8'h50, 8'hF7, 8'h50, 5'd8 },  // R2 C
    '{2'd1, 1'b0, 3'd7, 4'd6, 8'h81, 8'h00, 8'h01, 8'h00, 5'd16},  // R2 R8 memory
    '{2'd2, 1'b0, 3'd0, 4'd2, 8'h00, 8'hF0, 8'h01, 8'hF0, 5'd8 },  // R3 D
    '{2'd2, 1'b0, 3'd5, 4'd6, 8'h00, 8'h10, 8'h20, 8'h10, 5'd16},  // R3 R8 memory
    '{2'd2, 1'b0, 3'd4, 4'd5, 8'h10, 8'h00, 8'h10, 8'h00, 5'd8 },  // R3 L already set
    '{2'd3, 1'b0, 3'd0, 4'd4, 8'h80, 8'h00, 8'h00, 8'h90, 5'd8 },  // R5 H zero result
    '{2'd3, 1'b0, 3'd0, 4'd3, 8'h41, 8'h10, 8'h83, 8'h00, 5'd8 },  // R5 E carry in
    '{2'd3, 1'b1, 3'd0, 4'd0, 8'h80, 8'h00, 8'h00, 8'h10, 5'd4 },  // R6 Z forced 0
    '{2'd3, 1'b1, 3'd0, 4'd9, 8'h7F, 8'h10, 8'hFF, 8'h00, 5'd4 },  // R6 sel ignored
    '{2'd3, 1'b0, 3'd0, 4'd6, 8'hC0, 8'h00, 8'h80, 8'h10, 5'd16}   // R5 R8 memory
  };

  function automatic logic [7:0] bg(input int i);
    return 8'hA0 + 8'(i);
  endfunction

  task automatic run(input vec_t v, input int tag, input int stall);
    logic [2:0] tgt;
    bit         mem;
    int         n;
    bit         got;
    tgt = v.acc ? 3'd7 : v.sel[2:0];
    mem = !v.acc && v.sel == 4'd6;
    @(negedge clk);
    for (int i = 0; i < 8; i++) rf[i] = bg(i);
    if (mem) mem_byte = v.opnd; else rf[tgt] = v.opnd;
    flag_r = v.fin;
    rd_cnt = 0; wr_cnt = 0; order_bad = 0;
    hl = 16'h4000 + 16'(tag);
    op = v.op; accf = v.acc; idx = v.idx; sel = v.sel;
    mem_rdy = (stall == 0);
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    n = 0; got = 0;
    while (n < 60 && !got) begin
      @(negedge clk);
      n++;
      if (stall != 0 && n == stall) mem_rdy = 1'b1;
      if (done) begin
        got = 1;
        chk(cycles == v.ecost, "R4", "cycles_o", cycles, v.ecost);
        chk(!err, "R7", "err_o on legal", err, 0);
      end
    end
    chk(n == int'(v.ecost), "R4", "done cycle", n, v.ecost);
    @(negedge clk);
    chk(!done && !busy, "R9", "done pulse width", {done, busy}, 0);
    if (v.op == 2'd0) begin
      chk(wr_cnt == 0, "R1", "memory writes", wr_cnt, 0);
      if (!mem) chk(rf[tgt] == v.opnd, "R1", "operand kept", rf[tgt], v.opnd);
    end else if (mem) begin
      chk(mem_byte == v.eres, "R8", "memory result", mem_byte, v.eres);
      chk(wr_cnt == 1 && wr_addr == hl, "R8", "write address", wr_addr, hl);
      chk(order_bad == 0, "R8", "write before read", order_bad, 0);
    end else begin
      chk(rf[tgt] == v.eres, v.op == 2'd3 ? (v.acc ? "R6" : "R5") :
          (v.op == 2'd1 ? "R2" : "R3"), "register result", rf[tgt], v.eres);
    end
    if (mem) chk(rd_cnt == 1, "R8", "memory reads", rd_cnt, 1);
    chk(flag_r == v.eflg, v.op == 2'd0 ? "R1" : (v.op == 2'd3 ? "R5 R6" : "R2 R3"),
        "flags", flag_r, v.eflg);
    for (int i = 0; i < 8; i++)
      if (i != int'(tgt) || mem)
        chk(rf[i] == bg(i), "R7", "untouched register", rf[i], bg(i));
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    for (int i = 0; i < 8; i++) rf[i] = bg(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we && !flag_we, "R12", "reset state",
        {busy, done, mem_req, rf_we, flag_we}, 0);

    for (int k = 0; k < NV; k++) run(VEC[k], k, 0);

    // R8 stall: memory held off for the first cycles, still done at 16
    run('{2'd2, 1'b0, 3'd5, 4'd6, 8'h00, 8'h10, 8'h20, 8'h10, 5'd16}, 20, 4);

    // R7 illegal selector
    @(negedge clk);
    for (int i = 0; i < 8; i++) rf[i] = bg(i);
    flag_r = 8'h50; rd_cnt = 0; wr_cnt = 0;
    op = 2'd2; accf = 1'b0; idx = 3'd1; sel = 4'd9; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(done && err, "R7", "illegal done+err", {done, err}, 3);
    chk(cycles == 5'd1, "R7", "illegal cost", cycles, 1);
    @(negedge clk);
    chk(flag_r == 8'h50 && rd_cnt == 0 && wr_cnt == 0, "R7", "illegal side effects",
        flag_r, 8'h50);
    for (int i = 0; i < 8; i++) chk(rf[i] == bg(i), "R7", "illegal rf", rf[i], bg(i));

    // R11 start while busy is ignored
    @(negedge clk);
    for (int i = 0; i < 8; i++) rf[i] = bg(i);
    rf[0] = 8'hFF;
    op = 2'd1; accf = 1'b0; idx = 3'd0; sel = 4'd0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    n = 0;
    while (n < 40 && !done) begin
      @(negedge clk);
      n++;
      if (n == 2) begin op = 2'd2; idx = 3'd3; sel = 4'd1; start = 1'b1; end
      if (n == 3) start = 1'b0;
    end
    chk(n == 8, "R11", "first op timing", n, 8);
    repeat (3) @(negedge clk);
    chk(!busy, "R11", "no queued op", busy, 0);
    chk(rf[0] == 8'hFE, "R11", "first op result", rf[0], 8'hFE);
    chk(rf[1] == bg(1), "R11", "ignored op target", rf[1], bg(1));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule